// File: doc/BRIEF.md
# Average Absolute Deviation Pooling Engine

This block pools a stream of signed fixed-point feature-map samples. Instead of taking the largest sample or the mean of a window, it reports how spread out the window is: the sum of the absolute differences between every unordered pair of samples in the window, divided by N(N−1), where N is the window length. The window length and the step between windows are set at run time through two configuration inputs. These inputs are held stable between resets.

Samples arrive one per cycle when `in_valid_i` is high. Cycles with `in_valid_i` low are gaps that move nothing. Each time a window completes, every pairwise difference is formed in parallel, and the differences are summed and registered. The sum is then scaled by a stored fixed-point reciprocal and rounded. The block produces one pooled value per window, with a one-cycle valid flag.

Top module: `aad_pool`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o` is 0 and `out_data_o` is 0.
- R2: After reset, the first pooled value belongs to the window that closes on the P-th accepted sample, where P is `pool_size_i` (legal range 2 to MAX_POOL).
- R3: After the first window, another window closes on every S-th accepted sample, where S is `stride_i` (legal range 1 to MAX_STRIDE, S may exceed P). For n accepted samples with n ≥ P, the block gives floor((n−P)/S)+1 pooled values.
- R4: A window is the P most recently accepted samples, read as two's complement. Its value is round-half-up(D / (P(P−1))), where D is the sum of |a−b| over all P(P−1)/2 unordered pairs. The value is presented unsigned on `out_data_o` and clamped to 2^DATA_W−1.
- R5: With P = 2, the value is |a−b|/2 rounded half up.
- R6: `out_valid_o` is high for exactly one cycle. It rises two clock cycles after the edge that accepted the window's last sample.
- R7: A cycle with `in_valid_i` low neither shifts the window nor advances the fill or stride counting. Gaps in the input therefore leave every pooled value and its position in the sequence unchanged.
- R8: Each pairwise difference is non-negative whatever the order of its two samples, so swapping the two samples of a P = 2 window gives the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pool_size_i | input | PS_W | Window length P |
| stride_i | input | ST_W | Samples between window ends S |
| in_valid_i | input | 1 | Sample present |
| in_data_i | input | DATA_W | Signed sample |
| out_valid_o | output | 1 | Pooled value present |
| out_data_o | output | DATA_W | Pooled deviation, unsigned |

## Verification
The assertions run on every cycle. They check the fixed distance from an accepted sample to a valid output, the gap between outputs when the stride exceeds one, the range of the stride phase counter, that no window fires before the window is full, that each pair cell gives a non-negative difference, and that the configuration is legal. Only the bench scenarios can show that the values are correct against the rounded pairwise formula. The same holds for the count of windows across strides both shorter and longer than the window, for invariance to input gaps, for order independence, and for the full-scale extremes.

// File: rtl/aad_pool_pkg.sv
package aad_pool_pkg;
  // ceil(2^frac / m): never below the true reciprocal, so rounding stays exact
  function automatic longint recip_ceil(input int m, input int frac);
    longint one;
    one = longint'(1) << frac;
    return (m < 2) ? 64'd0 : (one + longint'(m) - 1) / longint'(m);
  endfunction
endpackage

// File: rtl/aad_pair_cell.sv
module aad_pair_cell #(
  parameter int DATA_W = 8
) (
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic        [DATA_W:0]   dev_o
);
  logic signed [DATA_W+1:0] diff_x, sgn_x, prod;

  always_comb begin
    diff_x = {{2{a_i[DATA_W-1]}}, a_i} - {{2{b_i[DATA_W-1]}}, b_i};
    sgn_x  = diff_x[DATA_W+1] ? '1 : (DATA_W+2)'(1);
    prod   = diff_x * sgn_x;
    dev_o  = prod[DATA_W:0];
    // R8
    abs_nonneg_chk: assert (prod[DATA_W+1] == 1'b0);
  end
endmodule

// File: rtl/aad_window_ctrl.sv
module aad_window_ctrl #(
  parameter int MAX_POOL   = 4,
  parameter int MAX_STRIDE = 8,
  localparam int PS_W = $clog2(MAX_POOL + 1),
  localparam int ST_W = $clog2(MAX_STRIDE + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [PS_W-1:0] pool_size_i,
  input  logic [ST_W-1:0] stride_i,
  output logic            fire_o
);
  logic [PS_W-1:0] fill_q, fill_n;
  logic [ST_W-1:0] phase_q, phase_n;
  logic            armed_q, hit;

  always_comb begin
    fill_n  = (fill_q == PS_W'(MAX_POOL)) ? fill_q : fill_q + 1'b1;
    phase_n = phase_q + 1'b1;
    hit     = armed_q ? (phase_n == stride_i) : (fill_n >= pool_size_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q  <= '0;
      phase_q <= '0;
      armed_q <= 1'b0;
      fire_o  <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (valid_i) begin
        fill_q <= fill_n;
        fire_o <= hit;
        if (hit) begin
          phase_q <= '0;
          armed_q <= 1'b1;
        end else if (armed_q) begin
          phase_q <= phase_n;
        end
      end
    end
  end

  // R3
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < stride_i);
  // R2
  fill_before_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> fill_q >= pool_size_i);
endmodule

// File: rtl/aad_normalizer.sv
module aad_normalizer #(
  parameter int DATA_W   = 8,
  parameter int MAX_POOL = 4,
  parameter int SUM_W    = 12,
  parameter int FRAC_W   = 18,
  localparam int PS_W = $clog2(MAX_POOL + 1)
) (
  input  logic [SUM_W-1:0]  sum_i,
  input  logic [PS_W-1:0]   pool_size_i,
  output logic [DATA_W-1:0] val_o
);
  localparam int PROD_W = SUM_W + FRAC_W + 1;

  logic [FRAC_W-1:0] recip_tab [MAX_POOL+1];

  for (genvar p = 0; p <= MAX_POOL; p++) begin : g_recip
    assign recip_tab[p] = FRAC_W'(aad_pool_pkg::recip_ceil(p * (p - 1), FRAC_W));
  end

  logic [PROD_W-1:0] prod;
  logic [SUM_W:0]    quo;

  always_comb begin
    prod = PROD_W'(sum_i) * PROD_W'(recip_tab[pool_size_i]);
    prod = prod + (PROD_W'(1) << (FRAC_W - 1));
    quo  = prod[FRAC_W +: SUM_W+1];
    val_o = (quo > (SUM_W+1)'({DATA_W{1'b1}})) ? '1 : quo[DATA_W-1:0];
  end
endmodule

// File: rtl/aad_pool.sv
module aad_pool #(
  parameter int DATA_W     = 8,
  parameter int MAX_POOL   = 4,
  parameter int MAX_STRIDE = 8,
  localparam int PS_W   = $clog2(MAX_POOL + 1),
  localparam int ST_W   = $clog2(MAX_STRIDE + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [PS_W-1:0]          pool_size_i,
  input  logic [ST_W-1:0]          stride_i,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_data_i,
  output logic                     out_valid_o,
  output logic [DATA_W-1:0]        out_data_o
);
  localparam int NPAIR  = MAX_POOL * (MAX_POOL - 1) / 2;
  localparam int DEV_W  = DATA_W + 1;
  localparam int SUM_W  = DEV_W + $clog2(NPAIR + 1);
  localparam int FRAC_W = SUM_W + $clog2(2 * MAX_POOL * (MAX_POOL - 1)) + 1;

  logic signed [DATA_W-1:0] win_q [MAX_POOL];
  logic [DEV_W-1:0]  dev   [NPAIR];
  logic [NPAIR-1:0]  pair_en;
  logic [SUM_W-1:0]  sum_c, sum_q;
  logic              fire_q, sum_v_q;
  logic [DATA_W-1:0] norm_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MAX_POOL; k++) win_q[k] <= '0;
    end else if (in_valid_i) begin
      win_q[0] <= in_data_i;
      for (int k = 1; k < MAX_POOL; k++) win_q[k] <= win_q[k-1];
    end
  end

  aad_window_ctrl #(.MAX_POOL(MAX_POOL), .MAX_STRIDE(MAX_STRIDE)) u_ctrl (
    .clk_i, .rst_ni, .valid_i(in_valid_i),
    .pool_size_i, .stride_i, .fire_o(fire_q)
  );

  // one cell per unordered pair; win_q[0] is the newest sample
  for (genvar i = 0; i < MAX_POOL - 1; i++) begin : g_row
    for (genvar j = i + 1; j < MAX_POOL; j++) begin : g_col
      localparam int IDX = i * MAX_POOL - i * (i + 1) / 2 + (j - i - 1);
      aad_pair_cell #(.DATA_W(DATA_W)) u_cell (
        .a_i(win_q[i]), .b_i(win_q[j]), .dev_o(dev[IDX])
      );
      assign pair_en[IDX] = (PS_W'(j) < pool_size_i);
    end
  end

  always_comb begin
    sum_c = '0;
    for (int p = 0; p < NPAIR; p++)
      if (pair_en[p]) sum_c = sum_c + SUM_W'(dev[p]);
  end

  aad_normalizer #(
    .DATA_W(DATA_W), .MAX_POOL(MAX_POOL), .SUM_W(SUM_W), .FRAC_W(FRAC_W)
  ) u_norm (
    .sum_i(sum_q), .pool_size_i, .val_o(norm_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q       <= '0;
      sum_v_q     <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      sum_v_q     <= fire_q;
      out_valid_o <= sum_v_q;
      if (fire_q)  sum_q      <= sum_c;
      if (sum_v_q) out_data_o <= norm_c;
    end
  end

  // R6
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i, 3));
  // R3
  stride_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stride_i > 1 && out_valid_o) |=> !out_valid_o);
  // R2
  cfg_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pool_size_i >= 2 && pool_size_i <= PS_W'(MAX_POOL) &&
    stride_i >= 1 && stride_i <= ST_W'(MAX_STRIDE));
endmodule

// File: tb/aad_pool_bench.sv
module aad_pool_bench;
  localparam int DATA_W = 8, MAX_POOL = 4, MAX_STRIDE = 8;
  localparam int PS_W = $clog2(MAX_POOL + 1), ST_W = $clog2(MAX_STRIDE + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [PS_W-1:0] pool_size = 2;
  logic [ST_W-1:0] stride = 1;
  logic in_valid = 1'b0;
  logic signed [DATA_W-1:0] in_data = '0;
  logic out_valid;
  logic [DATA_W-1:0] out_data;

  always #5 clk = ~clk;

  aad_pool u_aad_pool (
    .clk_i(clk), .rst_ni, .pool_size_i(pool_size), .stride_i(stride),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  int checks = 0, errors = 0, cycles = 0, n_out = 0;
  string tag = "R1";
  int hist[$];
  int obs[$];
  int accepted = 0;
  bit p1_v, p2_v, p3_v;
  int p1_d, p2_d, p3_d;

  // reference: window of last P accepted samples, output two edges after acceptance
  always @(posedge clk) begin
    if (!rst_ni) begin
      hist.delete(); accepted = 0;
      p1_v = 0; p2_v = 0; p3_v = 0;
    end else begin
      int P, S, s, m, e;
      bit f;
      p3_v = p2_v; p3_d = p2_d;
      p2_v = p1_v; p2_d = p1_d;
      p1_v = 0;
      if (in_valid) begin
        P = int'(pool_size); S = int'(stride);
        hist.push_back(int'(in_data));
        if (hist.size() > MAX_POOL) void'(hist.pop_front());
        accepted++;
        f = (accepted >= P) && ((accepted - P) % S == 0);
        if (f) begin
          s = 0;
          for (int a = hist.size() - P; a < hist.size(); a++)
            for (int b = a + 1; b < hist.size(); b++)
              s += (hist[a] > hist[b]) ? hist[a] - hist[b] : hist[b] - hist[a];
          m = P * (P - 1);
          e = (2 * s + m) / (2 * m);
          if (e > 255) e = 255;
          p1_v = 1; p1_d = e;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      checks++;
      if (out_valid !== p3_v) begin
        errors++;
        $display("FAIL %s/R6 valid: actual %0b expected %0b", tag, out_valid, p3_v);
      end
      if (out_valid) begin
        n_out++;
        obs.push_back(int'(out_data));
        if (p3_v) begin
          checks++;
          if (int'(out_data) != p3_d) begin
            errors++;
            $display("FAIL %s value: actual %0d expected %0d", tag, out_data, p3_d);
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic do_reset(input int p, input int s);
    @(negedge clk);
    rst_ni = 1'b0; in_valid = 1'b0;
    pool_size = PS_W'(p); stride = ST_W'(s);
    @(negedge clk); @(negedge clk);
    checks++;  // R1
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R1 reset: actual %0b/%0d expected 0/0", out_valid, out_data);
    end
    n_out = 0; obs.delete();
    rst_ni = 1'b1;
  endtask

  function automatic int gen(input int mode, input int k);
    if (mode == 2) return (k % 2 == 0) ? -128 : 127;
    return ((k * 37 + 11 * mode + (k * k) % 53) % 256) - 128;
  endfunction

  task automatic run(input int p, input int s, input int n, input int mode, input string t);
    do_reset(p, s);
    tag = t;
    for (int k = 0; k < n; k++) begin
      if (mode == 1 && k % 3 == 1) begin
        in_valid = 1'b1; in_data = DATA_W'(gen(mode, k));
        @(negedge clk);
        in_valid = 1'b0; in_data = 8'sh55;  // ignored gap data
      end else begin
        in_valid = 1'b1; in_data = DATA_W'(gen(mode, k));
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    checks++;  // R2 R3
    if (n_out != (n - p) / s + 1) begin
      errors++;
      $display("FAIL %s/R2/R3 count: actual %0d expected %0d", t, n_out, (n - p) / s + 1);
    end
  endtask

  task automatic send(input int v);
    in_valid = 1'b1; in_data = DATA_W'(v);
    @(negedge clk);
  endtask

  initial begin
    run(2, 2, 20, 0, "R5");
    run(4, 1, 24, 1, "R4/R7");
    run(3, 2, 21, 0, "R2/R3");
    run(4, 5, 30, 0, "R3");
    run(4, 4, 16, 2, "R4");
    run(2, 1, 15, 0, "R5");

    do_reset(2, 2);
    tag = "R8";
    send(-100); send(37); send(37); send(-100);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    checks++;  // R8
    if (obs.size() != 2 || obs[0] != obs[1] || obs[0] != 69) begin
      errors++;
      $display("FAIL R8 order: actual %0d/%0d expected 69/69",
               obs.size() > 0 ? obs[0] : -1, obs.size() > 1 ? obs[1] : -1);
    end
    finish_run();
  end
endmodule